// File: doc/BRIEF.md
# Paged Transfer Request Packetizer

The packetizer turns one long transfer into a series of read-request descriptors. Each descriptor carries a 48-bit destination offset, a byte length and a two-bit speed code. Each request is sized so that it never exceeds a programmable power-of-two payload limit. When a page size is configured, a request also never runs past the next page boundary.

Software drives the block through a two-bit command field and reads back a two-bit state. The commands are start/resume, init-start (reload from the configuration inputs) and abort. The states are idle, pending, busy and page-fault. In long-block mode the 16-bit size field holds a count of fixed-size blocks instead of a byte count, and the count goes down by one for each block sent. A clear strobe flushes the offset and the remaining count. A separate status bit records that the destination ID has been written since the last bus reset.

Top module: `req_packetizer`

## Requirements
- R1: After reset, status_o is 00 (IDLE), req_valid_o, clear_o and nodeid_vld_o are 0, and blk_cnt_o and req_offset_o are 0.
- R2: An accepted init-start (command 11) shows status 11 (PEND) for exactly one cycle, with req_offset_o = {dst_ofs_hi_i, dst_ofs_lo_i} and blk_cnt_o = blk_field_i. The status then becomes 10 (BUSY) or 01 (PAGEFAULT).
- R3: In byte mode a request length is the smallest of three values: the remaining byte count, 2^(max_pl_i+2), and, when page_sz_i is nonzero, the bytes left to the next 2^(page_sz_i+8) boundary. A page_sz_i of 0 applies no page clipping.
- R4: When a page size is set, (offset mod page size) + length never exceeds the page size.
- R5: Each cycle with req_valid_o and req_ready_i both high advances the offset by the request length and lowers blk_cnt_o by that length. While req_ready_i is low, req_valid_o stays high and the offset and count hold.
- R6: The handshake that brings the remaining count to 0 returns the status to IDLE on the next cycle.
- R7: In long-block mode (long_blk_i = 1) every request is 2^(max_pl_i+2) bytes long and blk_cnt_o drops by 1 per request. A start enters PAGEFAULT if a page size is set and either the page is smaller than the payload or the offset is not a multiple of the payload.
- R8: Start (command 10) resumes from the current offset and count. Starting with a count of 0 enters PAGEFAULT. Start and init-start are ignored while BUSY.
- R9: Abort (command 01) forces IDLE on the next cycle from any state and drops req_valid_o. The offset and count are kept.
- R10: A start or init-start given while speed_i = 11 is ignored. Otherwise the speed code given with the command appears on req_speed_o.
- R11: A clear accepted in IDLE or PAGEFAULT raises clear_o for exactly one cycle and zeroes the offset and count. A clear given while BUSY is ignored.
- R12: nodeid_vld_o is set by dst_id_we_i and cleared by bus_reset_i. Bus reset has priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 2 | Command: 00 nop, 10 start, 11 init-start, 01 abort |
| clear_i | input | 1 | Clear request |
| speed_i | input | 2 | Speed code: 00, 01, 10 valid; 11 invalid |
| max_pl_i | input | 4 | Payload exponent; limit 2^(n+2) bytes |
| page_sz_i | input | 3 | Page exponent; page 2^(n+8) bytes; 0 means none |
| long_blk_i | input | 1 | Long-block mode select |
| blk_field_i | input | 16 | Byte count, or block count in long-block mode |
| dst_ofs_hi_i | input | 16 | Destination offset, high part |
| dst_ofs_lo_i | input | 32 | Destination offset, low part |
| dst_id_we_i | input | 1 | Destination ID written |
| bus_reset_i | input | 1 | Bus reset event |
| status_o | output | 2 | State: 00 IDLE, 10 BUSY, 11 PEND, 01 PAGEFAULT |
| clear_o | output | 1 | Clear in progress |
| nodeid_vld_o | output | 1 | Destination ID valid |
| blk_cnt_o | output | 16 | Remaining bytes or blocks |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted |
| req_offset_o | output | 48 | Current destination offset |
| req_len_o | output | 18 | Request length in bytes |
| req_speed_o | output | 2 | Request speed code |

## Verification
The hardest case to reach from the ports is a page-boundary clip that falls between two payload-sized requests. Here the page limit, not the payload or the remaining count, sets a length, and the offset must carry from the low into the high destination word. The bench sweeps payload exponents, page exponents, odd start offsets (one just below a 32-bit carry) and transfer lengths. It predicts every request length and offset arithmetically. The abort, resume and clear paths are reached by holding ready low partway through a transfer, so that the offset and count sit frozen at a known non-zero point.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_FAULT = 2'b01,
    ST_BUSY  = 2'b10,
    ST_PEND  = 2'b11
  } xfer_st_e;

  localparam logic [1:0] CMD_NOP   = 2'b00;
  localparam logic [1:0] CMD_ABORT = 2'b01;
  localparam logic [1:0] CMD_START = 2'b10;
  localparam logic [1:0] CMD_INIT  = 2'b11;
  localparam logic [1:0] SPD_BAD   = 2'b11;
endpackage

// File: rtl/pkt_len_calc.sv
module pkt_len_calc #(
  parameter int CNT_W = 16,
  parameter int PL_W  = 4,
  parameter int PG_W  = 3,
  parameter int LEN_W = (1 << PL_W) + 2
) (
  input  logic [LEN_W-1:0] ofs_lo_i,
  input  logic [CNT_W-1:0] rem_i,
  input  logic [PL_W-1:0]  pl_i,
  input  logic [PG_W-1:0]  pg_i,
  input  logic             long_i,
  output logic [LEN_W-1:0] len_o,
  output logic             fault_o
);
  logic [LEN_W-1:0] pay, pg_bytes, pg_left, rem_w;
  logic             pg_en;

  always_comb begin
    pay      = LEN_W'(1) << (int'(pl_i) + 2);
    pg_en    = (pg_i != '0);
    pg_bytes = LEN_W'(1) << (int'(pg_i) + 8);
    pg_left  = pg_bytes - (ofs_lo_i & (pg_bytes - LEN_W'(1)));
    rem_w    = LEN_W'(rem_i);

    len_o = rem_w;
    if (pay < len_o) len_o = pay;
    if (pg_en && (pg_left < len_o)) len_o = pg_left;
    if (long_i) len_o = pay;

    // fixed-size blocks must fit whole pages
    fault_o = (rem_i == '0) ||
              (long_i && pg_en &&
               ((pg_bytes < pay) || ((ofs_lo_i & (pay - LEN_W'(1))) != '0)));
  end
endmodule

// File: rtl/pkt_ctrl.sv
module pkt_ctrl
  import pkt_pkg::*;
#(
  parameter int OFS_W = 48,
  parameter int CNT_W = 16,
  parameter int PL_W  = 4,
  parameter int PG_W  = 3,
  parameter int LEN_W = (1 << PL_W) + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [1:0]       cmd_i,
  input  logic             clear_i,
  input  logic [1:0]       spd_i,
  input  logic [PL_W-1:0]  pl_i,
  input  logic [PG_W-1:0]  pg_i,
  input  logic             long_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             ready_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             fault_i,
  output logic [1:0]       st_o,
  output logic             clear_o,
  output logic             valid_o,
  output logic [OFS_W-1:0] ofs_o,
  output logic [CNT_W-1:0] rem_o,
  output logic [1:0]       spd_o,
  output logic [PL_W-1:0]  pl_o,
  output logic [PG_W-1:0]  pg_o,
  output logic             long_o
);
  xfer_st_e         st_q;
  logic [OFS_W-1:0] ofs_q;
  logic [CNT_W-1:0] rem_q, dec;
  logic             clr_q, long_q, abort_cmd, go_cmd;
  logic [1:0]       spd_q;
  logic [PL_W-1:0]  pl_q;
  logic [PG_W-1:0]  pg_q;

  assign abort_cmd = cmd_we_i && (cmd_i == CMD_ABORT);
  assign go_cmd    = cmd_we_i && cmd_i[1] && (spd_i != SPD_BAD);
  assign dec       = long_q ? CNT_W'(1) : len_i[CNT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ofs_q  <= '0;
      rem_q  <= '0;
      clr_q  <= 1'b0;
      spd_q  <= '0;
      pl_q   <= '0;
      pg_q   <= '0;
      long_q <= 1'b0;
    end else if (abort_cmd) begin
      st_q <= ST_IDLE;
    end else if (clr_q) begin
      ofs_q <= '0;
      rem_q <= '0;
      clr_q <= 1'b0;
      st_q  <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_FAULT: begin
          if (clear_i) begin
            clr_q <= 1'b1;
          end else if (go_cmd) begin
            st_q   <= ST_PEND;
            spd_q  <= spd_i;
            pl_q   <= pl_i;
            pg_q   <= pg_i;
            long_q <= long_i;
            if (cmd_i == CMD_INIT) begin
              ofs_q <= ofs_i;
              rem_q <= cnt_i;
            end
          end
        end
        ST_PEND: st_q <= fault_i ? ST_FAULT : ST_BUSY;
        ST_BUSY: begin
          if (ready_i) begin
            ofs_q <= ofs_q + OFS_W'(len_i);
            rem_q <= rem_q - dec;
            if (rem_q == dec) st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o    = st_q;
  assign clear_o = clr_q;
  assign valid_o = (st_q == ST_BUSY);
  assign ofs_o   = ofs_q;
  assign rem_o   = rem_q;
  assign spd_o   = spd_q;
  assign pl_o    = pl_q;
  assign pg_o    = pg_q;
  assign long_o  = long_q;

  logic [LEN_W-1:0] pg_sz_chk;
  logic [LEN_W:0]   pg_end_chk;
  assign pg_sz_chk  = LEN_W'(1) << (int'(pg_q) + 8);
  assign pg_end_chk = {1'b0, ofs_q[LEN_W-1:0] & (pg_sz_chk - LEN_W'(1))} + {1'b0, len_i};

  assert_pend_once_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PEND) && !abort_cmd |=> (st_q == ST_BUSY) || (st_q == ST_FAULT));
  assert_len_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (len_i != '0) && (long_q || (len_i <= LEN_W'(rem_q))));
  assert_no_cross_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && (pg_q != '0) |-> pg_end_chk <= {1'b0, pg_sz_chk});
  assert_stall_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && !abort_cmd |=> valid_o && $stable(ofs_q) && $stable(rem_q));
  assert_last_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !abort_cmd && (rem_q == dec) |=> st_q == ST_IDLE);
  assert_abort_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_cmd |=> (st_q == ST_IDLE) && !valid_o);
  assert_bad_speed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) && cmd_we_i && cmd_i[1] && (spd_i == SPD_BAD) && !clr_q |=> st_q == ST_IDLE);
  assert_clear_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |=> !clr_q);
  assert_clear_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BUSY) && clear_i |=> !clr_q);
endmodule

// File: rtl/req_packetizer.sv
module req_packetizer #(
  parameter int OFS_W = 48,
  parameter int HI_W  = 16,
  parameter int CNT_W = 16,
  parameter int PL_W  = 4,
  parameter int PG_W  = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cmd_we_i,
  input  logic [1:0]                  cmd_i,
  input  logic                        clear_i,
  input  logic [1:0]                  speed_i,
  input  logic [PL_W-1:0]             max_pl_i,
  input  logic [PG_W-1:0]             page_sz_i,
  input  logic                        long_blk_i,
  input  logic [CNT_W-1:0]            blk_field_i,
  input  logic [HI_W-1:0]             dst_ofs_hi_i,
  input  logic [OFS_W-HI_W-1:0]       dst_ofs_lo_i,
  input  logic                        dst_id_we_i,
  input  logic                        bus_reset_i,
  output logic [1:0]                  status_o,
  output logic                        clear_o,
  output logic                        nodeid_vld_o,
  output logic [CNT_W-1:0]            blk_cnt_o,
  output logic                        req_valid_o,
  input  logic                        req_ready_i,
  output logic [OFS_W-1:0]            req_offset_o,
  output logic [(1 << PL_W)+1:0]      req_len_o,
  output logic [1:0]                  req_speed_o
);
  localparam int LEN_W = (1 << PL_W) + 2;

  logic [OFS_W-1:0] ofs_cur;
  logic [CNT_W-1:0] rem_cur;
  logic [LEN_W-1:0] len;
  logic             fault, long_cur;
  logic [PL_W-1:0]  pl_cur;
  logic [PG_W-1:0]  pg_cur;
  logic             nodeid_q;

  pkt_len_calc #(.CNT_W(CNT_W), .PL_W(PL_W), .PG_W(PG_W), .LEN_W(LEN_W)) u_len (
    .ofs_lo_i (ofs_cur[LEN_W-1:0]),
    .rem_i    (rem_cur),
    .pl_i     (pl_cur),
    .pg_i     (pg_cur),
    .long_i   (long_cur),
    .len_o    (len),
    .fault_o  (fault)
  );

  pkt_ctrl #(.OFS_W(OFS_W), .CNT_W(CNT_W), .PL_W(PL_W), .PG_W(PG_W), .LEN_W(LEN_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_we_i (cmd_we_i),
    .cmd_i    (cmd_i),
    .clear_i  (clear_i),
    .spd_i    (speed_i),
    .pl_i     (max_pl_i),
    .pg_i     (page_sz_i),
    .long_i   (long_blk_i),
    .cnt_i    (blk_field_i),
    .ofs_i    ({dst_ofs_hi_i, dst_ofs_lo_i}),
    .ready_i  (req_ready_i),
    .len_i    (len),
    .fault_i  (fault),
    .st_o     (status_o),
    .clear_o  (clear_o),
    .valid_o  (req_valid_o),
    .ofs_o    (ofs_cur),
    .rem_o    (rem_cur),
    .spd_o    (req_speed_o),
    .pl_o     (pl_cur),
    .pg_o     (pg_cur),
    .long_o   (long_cur)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          nodeid_q <= 1'b0;
    else if (bus_reset_i) nodeid_q <= 1'b0;
    else if (dst_id_we_i) nodeid_q <= 1'b1;
  end

  assign nodeid_vld_o = nodeid_q;
  assign blk_cnt_o    = rem_cur;
  assign req_offset_o = ofs_cur;
  assign req_len_o    = len;

  assert_nodeid_clr_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> !nodeid_vld_o);
  assert_nodeid_set_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_id_we_i && !bus_reset_i |=> nodeid_vld_o);
endmodule

// File: tb/tb_req_packetizer.sv
`timescale 1ns/1ps
module tb_req_packetizer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [1:0]  cmd = 2'b00;
  logic        clr = 1'b0;
  logic [1:0]  spd = 2'b00;
  logic [3:0]  pl = 4'd0;
  logic [2:0]  pg = 3'd0;
  logic        lng = 1'b0;
  logic [15:0] fld = 16'd0;
  logic [15:0] ohi = 16'd0;
  logic [31:0] olo = 32'd0;
  logic        id_we = 1'b0;
  logic        brst = 1'b0;
  logic        rdy = 1'b0;
  logic [1:0]  status;
  logic        clear_o, nid;
  logic [15:0] cnt;
  logic        vld;
  logic [47:0] ofs;
  logic [17:0] len;
  logic [1:0]  rspd;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  req_packetizer dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_i(cmd), .clear_i(clr),
    .speed_i(spd), .max_pl_i(pl), .page_sz_i(pg), .long_blk_i(lng), .blk_field_i(fld),
    .dst_ofs_hi_i(ohi), .dst_ofs_lo_i(olo), .dst_id_we_i(id_we), .bus_reset_i(brst),
    .status_o(status), .clear_o(clear_o), .nodeid_vld_o(nid), .blk_cnt_o(cnt),
    .req_valid_o(vld), .req_ready_i(rdy), .req_offset_o(ofs), .req_len_o(len),
    .req_speed_o(rspd)
  );

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic issue(logic [1:0] c);
    cmd_we = 1'b1; cmd = c;
    step();
    cmd_we = 1'b0; cmd = 2'b00;
  endtask

  function automatic longint unsigned exp_len(int p, int g, longint unsigned o, longint unsigned r);
    longint unsigned l, pay, pgb, left;
    pay = 64'd1 << (p + 2);
    l = (r < pay) ? r : pay;
    if (g != 0) begin
      pgb = 64'd1 << (g + 8);
      left = pgb - (o % pgb);
      if (left < l) l = left;
    end
    return l;
  endfunction

  task automatic set_ofs(longint unsigned o);
    ohi = o[47:32]; olo = o[31:0];
  endtask

  // drains a byte-mode transfer that is already BUSY, ready held high
  task automatic drain(int p, int g, longint unsigned o, longint unsigned r, logic [1:0] s);
    longint unsigned el, pgb;
    while (r > 0) begin
      el = exp_len(p, g, o, r);
      chk("R5 valid", vld, 1);
      chk("R3 length", len, el);
      chk("R5 offset", ofs, o);
      chk("R10 speed", rspd, s);
      if (g != 0) begin
        pgb = 64'd1 << (g + 8);
        chk("R4 page crossing", ((o % pgb) + len) > pgb, 0);
      end
      step();
      o = (o + el) & 48'hFFFF_FFFF_FFFF;
      r = r - el;
      chk("R5 count", cnt, r);
    end
    chk("R6 idle at end", status, 2'b00);
    chk("R6 valid low", vld, 0);
  endtask

  task automatic run_short(int p, int g, longint unsigned o, int n, logic [1:0] s);
    pl = 4'(p); pg = 3'(g); lng = 1'b0; fld = 16'(n); spd = s; set_ofs(o); rdy = 1'b1;
    issue(2'b11);
    chk("R2 pend", status, 2'b11);
    chk("R2 offset load", ofs, o);
    chk("R2 count load", cnt, n);
    step();
    chk("R2 busy", status, 2'b10);
    drain(p, g, o, n, s);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    longint unsigned ofs_tab [3] = '{48'h0, 48'h0000_FFFF_FFF0, 48'h1234_0000_0103};
    int len_tab [3] = '{1, 37, 300};
    longint unsigned o;
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 status", status, 2'b00);
    chk("R1 valid", vld, 0);
    chk("R1 clear", clear_o, 0);
    chk("R1 nodeid", nid, 0);
    chk("R1 count", cnt, 0);
    chk("R1 offset", ofs, 0);

    // R3 R4 R5 R6 sweep
    for (int p = 0; p < 4; p++)
      for (int g = 0; g < 3; g++)
        for (int i = 0; i < 3; i++)
          for (int j = 0; j < 3; j++)
            run_short(p, g, ofs_tab[i], len_tab[j], 2'((p + g + i) % 3));

    // R7 long-block mode
    pl = 4'd2; pg = 3'd1; lng = 1'b1; fld = 16'd5; spd = 2'b01; set_ofs(48'h100); rdy = 1'b1;
    issue(2'b11);
    step();
    chk("R7 busy", status, 2'b10);
    o = 48'h100;
    for (int k = 5; k > 0; k--) begin
      chk("R7 block length", len, 16);
      chk("R7 block offset", ofs, o);
      chk("R7 block count", cnt, k);
      step();
      o += 16;
    end
    chk("R7 count done", cnt, 0);
    chk("R7 idle", status, 2'b00);
    pl = 4'd8; pg = 3'd1; fld = 16'd3; set_ofs(48'h0);
    issue(2'b11);
    step();
    chk("R7 page smaller than block", status, 2'b01);
    pl = 4'd2; set_ofs(48'h104);
    issue(2'b11);
    step();
    chk("R7 misaligned block", status, 2'b01);
    issue(2'b01);
    chk("R9 abort from fault", status, 2'b00);
    lng = 1'b0;

    // R8 zero length
    pl = 4'd2; pg = 3'd0; fld = 16'd0; set_ofs(48'h40);
    issue(2'b11);
    step();
    chk("R8 zero length fault", status, 2'b01);

    // R5 stall, R8 busy ignore, R11 clear ignored, R9 abort, R8 resume
    fld = 16'd100; spd = 2'b10; rdy = 1'b1;
    issue(2'b11);
    step();
    step();
    rdy = 1'b0;
    step();
    chk("R5 stall valid", vld, 1);
    chk("R5 stall offset", ofs, 48'h50);
    chk("R5 stall count", cnt, 84);
    step(); step();
    chk("R5 stall hold", ofs, 48'h50);
    set_ofs(48'h9000); fld = 16'd7;
    issue(2'b11);
    chk("R8 init ignored busy", status, 2'b10);
    chk("R8 offset kept busy", ofs, 48'h50);
    clr = 1'b1; step(); clr = 1'b0;
    chk("R11 clear ignored busy", clear_o, 0);
    step();
    chk("R11 clear ignored flag", clear_o, 0);
    chk("R11 count kept", cnt, 84);
    issue(2'b01);
    chk("R9 abort idle", status, 2'b00);
    chk("R9 abort valid", vld, 0);
    chk("R9 count kept", cnt, 84);
    chk("R9 offset kept", ofs, 48'h50);
    rdy = 1'b1;
    issue(2'b10);
    chk("R8 resume pend", status, 2'b11);
    chk("R8 resume offset", ofs, 48'h50);
    step();
    chk("R8 resume busy", status, 2'b10);
    drain(2, 0, 48'h50, 84, 2'b10);
    issue(2'b10);
    step();
    chk("R8 start empty fault", status, 2'b01);

    // R11 clear from fault
    clr = 1'b1; step(); clr = 1'b0;
    chk("R11 clear flag", clear_o, 1);
    step();
    chk("R11 clear done", clear_o, 0);
    chk("R11 offset zero", ofs, 0);
    chk("R11 count zero", cnt, 0);
    chk("R11 idle", status, 2'b00);

    // R10 invalid speed
    spd = 2'b11; fld = 16'd20;
    issue(2'b11);
    chk("R10 bad speed ignored", status, 2'b00);
    step();
    chk("R10 bad speed still idle", status, 2'b00);
    chk("R10 no load", cnt, 0);

    // R12 node-id valid
    id_we = 1'b1; step(); id_we = 1'b0;
    chk("R12 set", nid, 1);
    step();
    chk("R12 hold", nid, 1);
    brst = 1'b1; step(); brst = 1'b0;
    chk("R12 bus reset", nid, 0);
    id_we = 1'b1; brst = 1'b1; step(); id_we = 1'b0; brst = 1'b0;
    chk("R12 reset priority", nid, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule